// File: doc/BRIEF.md
# Programmable Length Delay Buffer

This block holds a stream of 10-bit words for a run-time programmable number of clock cycles. Each word passes through an entry register, a RAM-backed variable section of 0 to 1279 stages, and an exit register, so the total latency N runs from 2 to 1281 cycles. The block serves line-delay and alignment work in video and signal pipelines, where the delay has to be retuned while the chip is running.

A registered mode input picks the source of the entry register. In delay mode it takes a fresh input word on every active edge. In loop mode it takes the exit register, so the N stored words rotate as a circular buffer. A hold input freezes every piece of internal state. An active-low output enable drives the output port or leaves it at high impedance. A compile-time parameter chooses the clock edge on which all internal state moves.

Top module: `vdl_top`

## Requirements
- R1: While reset is active and after it is released, the exit register holds 0, the programmed length is 0 (N = 2) and the block is in delay mode.
- R2: In delay mode with programmed length L, a word sampled on active edge k appears on `dout` after edge k+L+1, so the total latency is N = L+2 cycles.
- R3: `len_val` is an 11-bit unsigned value with bit 10 as the MSB. It is copied into the length register only on an active edge where `len_ld` is 1. At any other time it has no effect.
- R4: A loaded value above 1279 is stored as 1279, which gives N = 1281.
- R5: With length 0 the variable section is bypassed and a word sampled on edge k is on `dout` after edge k+1.
- R6: With `loop_en` registered high (loop mode), the entry register takes the exit register's word. The buffer then replays its N words with period N, and `din` has no effect.
- R7: `loop_en` is registered on one active edge, and the data path follows the new mode from the next active edge.
- R8: `hold` is sampled on every active edge. An edge that follows a sample of 1 changes no state: the data path, the pointer, the length register and the mode register all keep their values, and a `len_ld` pulse on that edge is lost. The edge that samples `hold` still operates.
- R9: With `oe_n` = 0, `dout` is driven with the exit register. With `oe_n` = 1, `dout` is high impedance. `oe_n` never alters data movement.
- R10: Parameter `RISING_EDGE` = 1 moves all state on the rising clock edge, and 0 moves it on the falling edge. Outputs do not change at the other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 10 | Data word accepted in delay mode |
| len_val | input | 11 | Requested length L (latency minus two) |
| len_ld | input | 1 | Load strobe for `len_val` |
| loop_en | input | 1 | Mode request: 0 delay, 1 loop |
| hold | input | 1 | Freeze request, active high |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 10 | Delayed data, tri-state |

## Verification
A length-load strobe can land on the same edge as a frozen clock, and so can a change of data. The bench provokes both by raising `hold` one edge before it pulses `len_ld` with a new length and changes `din`. It then judges the result from the output timing alone: the frozen edge repeats the previous output, the word presented on that edge never comes out, and the next words still come out with the old two-cycle latency. A second overlap is a mode change on the edge that also accepts the last fresh word. The bench judges this one by whether that word joins the rotating sequence.

// File: rtl/vdl_pkg.sv
package vdl_pkg;
  localparam int VDL_DATA_W  = 10;
  localparam int VDL_LEN_W   = 11;
  localparam int VDL_MAX_LEN = 1279;

  typedef enum logic {
    MODE_DELAY  = 1'b0,
    MODE_RECIRC = 1'b1
  } vdl_mode_e;
endpackage

// File: rtl/vdl_ctrl.sv
module vdl_ctrl
  import vdl_pkg::*;
#(
  parameter int LEN_W   = VDL_LEN_W,
  parameter int MAX_LEN = VDL_MAX_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             len_ld_i,
  input  logic [LEN_W-1:0] len_val_i,
  input  logic             mode_i,
  output logic             en_o,
  output logic             load_o,
  output logic [LEN_W-1:0] len_o,
  output vdl_mode_e        mode_o
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  logic             hold_q;
  logic [LEN_W-1:0] len_q, len_d, len_sat;
  vdl_mode_e        mode_q, mode_d;
  logic             en, load;

  assign en      = ~hold_q;
  assign load    = en & len_ld_i;
  assign len_sat = (len_val_i > LEN_CAP) ? LEN_CAP : len_val_i;

  always_comb begin
    len_d  = len_q;
    mode_d = mode_q;
    if (load) len_d = len_sat;
    if (en)   mode_d = vdl_mode_e'(mode_i);
  end

  // hold register samples on every edge, so release is always seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      len_q  <= '0;
      mode_q <= MODE_DELAY;
    end else begin
      hold_q <= hold_i;
      len_q  <= len_d;
      mode_q <= mode_d;
    end
  end

  assign en_o   = en;
  assign load_o = load;
  assign len_o  = len_q;
  assign mode_o = mode_q;

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_CAP);  // R4
  AST_LEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !len_ld_i |=> $stable(len_q));  // R3
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> ($stable(len_q) && $stable(mode_q)));  // R8
endmodule

// File: rtl/vdl_ring.sv
module vdl_ring #(
  parameter int DATA_W = 10,
  parameter int LEN_W  = 11,
  parameter int DEPTH  = 1280
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, wp_d;
  logic              active;

  assign active = en_i && (len_i != '0);

  // same slot is read then overwritten: the read word is L steps old
  assign rd_data_o = mem[wp_q];

  always_comb begin
    wp_d = wp_q;
    if (clr_i) begin
      wp_d = '0;
    end else if (active) begin
      if ((32'(wp_q) + 32'd1) >= 32'(len_i)) wp_d = '0;
      else                                   wp_d = wp_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_d;
  end

  always_ff @(posedge clk) begin
    if (active) mem[wp_q] <= wr_data_i;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_i != '0) |-> (32'(wp_q) < 32'(len_i)));  // R2
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> $stable(wp_q));  // R8
endmodule

// File: rtl/vdl_top.sv
module vdl_top
  import vdl_pkg::*;
#(
  parameter int DATA_W      = VDL_DATA_W,
  parameter int LEN_W       = VDL_LEN_W,
  parameter int MAX_LEN     = VDL_MAX_LEN,
  parameter bit RISING_EDGE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              len_ld,
  input  logic              loop_en,
  input  logic              hold,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = MAX_LEN + 1;

  logic              clk_i;
  logic              en, load;
  logic [LEN_W-1:0]  len_q;
  vdl_mode_e         mode_q;
  logic [DATA_W-1:0] in_q, in_d, out_q, out_d, ring_rd;

  generate
    if (RISING_EDGE) begin : g_pos_edge
      assign clk_i = clk;
    end else begin : g_neg_edge
      assign clk_i = ~clk;
    end
  endgenerate

  vdl_ctrl #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk       (clk_i),
    .rst_n     (rst_n),
    .hold_i    (hold),
    .len_ld_i  (len_ld),
    .len_val_i (len_val),
    .mode_i    (loop_en),
    .en_o      (en),
    .load_o    (load),
    .len_o     (len_q),
    .mode_o    (mode_q)
  );

  vdl_ring #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_ring (
    .clk       (clk_i),
    .rst_n     (rst_n),
    .en_i      (en),
    .clr_i     (load),
    .len_i     (len_q),
    .wr_data_i (in_q),
    .rd_data_o (ring_rd)
  );

  always_comb begin
    in_d  = in_q;
    out_d = out_q;
    if (en) begin
      in_d  = (mode_q == MODE_RECIRC) ? out_q : din;
      out_d = (len_q == '0) ? in_q : ring_rd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q  <= in_d;
      out_q <= out_d;
    end
  end

  assign dout = oe_n ? 'z : out_q;

  AST_FEED_FRESH: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && mode_q == MODE_DELAY) |=> (in_q == $past(din)));  // R2
  AST_FEED_LOOP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && mode_q == MODE_RECIRC) |=> (in_q == $past(out_q)));  // R6
  AST_DATA_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!en) |=> ($stable(out_q) && $stable(in_q)));  // R8
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && len_q == '0) |=> (out_q == $past(in_q)));  // R5
endmodule

// File: tb/tb_vdl_top.sv
module tb_vdl_top;
  logic        clk, rst_n, len_ld, loop_en, hold, oe_n;
  logic [9:0]  din;
  logic [10:0] len_val;
  wire  [9:0]  dout;
  int          n_chk, n_fail;
  logic [9:0]  v;

  for (genvar g = 0; g < 10; g++) begin : g_pu
    pullup pu (dout[g]);
  end

  vdl_top dut (
    .clk(clk), .rst_n(rst_n), .din(din), .len_val(len_val), .len_ld(len_ld),
    .loop_en(loop_en), .hold(hold), .oe_n(oe_n), .dout(dout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // row: {oe_n, check, din, expected}; length 3 gives N = 5
  localparam logic [21:0] TBL [12] = '{
    {1'b0, 1'b0, 10'h001, 10'h000},
    {1'b0, 1'b0, 10'h002, 10'h000},
    {1'b0, 1'b0, 10'h004, 10'h000},
    {1'b0, 1'b0, 10'h008, 10'h000},
    {1'b0, 1'b1, 10'h010, 10'h001},
    {1'b0, 1'b1, 10'h020, 10'h002},
    {1'b1, 1'b1, 10'h040, 10'h3FF},
    {1'b1, 1'b1, 10'h080, 10'h3FF},
    {1'b0, 1'b1, 10'h100, 10'h010},
    {1'b0, 1'b1, 10'h200, 10'h020},
    {1'b0, 1'b1, 10'h0C3, 10'h040},
    {1'b0, 1'b1, 10'h155, 10'h080}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: dout=%h expected=completion", dout);
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; din = '0; len_val = '0; len_ld = 1'b0;
    loop_en = 1'b0; hold = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset value", dout, 10'h000);
    rst_n = 1'b1;
    tick();

    // delay mode, L = 3, table walk; len_val without strobe ignored (R3)
    len_val = 11'd3; len_ld = 1'b1;
    tick();
    len_ld = 1'b0; len_val = 11'd9;
    for (int i = 0; i < 12; i++) begin
      oe_n = TBL[i][21];
      din  = TBL[i][19:10];
      tick();
      if (TBL[i][20]) check("R2/R3/R9 table row", dout, TBL[i][9:0]);
    end
    oe_n = 1'b0;

    // loop mode, L = 2, N = 4; mode raised on edge taking last fresh word
    len_val = 11'd2; len_ld = 1'b1;
    tick();
    len_ld = 1'b0;
    din = 10'h0A1; tick();
    din = 10'h0B2; tick();
    din = 10'h0C3; tick();
    din = 10'h0D4; loop_en = 1'b1; tick();
    check("R6 loop first", dout, 10'h0A1);
    din = 10'h3E7;
    tick(); check("R6 loop B", dout, 10'h0B2);
    tick(); check("R6 loop C", dout, 10'h0C3);
    tick(); check("R7 word on mode edge kept", dout, 10'h0D4);
    tick(); check("R6 period wrap A", dout, 10'h0A1);
    tick(); check("R6 period wrap B", dout, 10'h0B2);
    tick(); check("R6 period wrap C", dout, 10'h0C3);
    tick(); check("R6 period wrap D", dout, 10'h0D4);
    loop_en = 1'b0;
    tick();

    // hold with length load on frozen edge, L = 0
    len_val = 11'd0; len_ld = 1'b1;
    tick();
    len_ld = 1'b0;
    v = dout;
    din = 10'h111;
    #2;
    check("R10 no change off active edge", dout, v);
    tick();
    din = 10'h122; hold = 1'b1; tick();
    check("R5 two-register latency", dout, 10'h111);
    din = 10'h133; hold = 1'b0; len_val = 11'd5; len_ld = 1'b1; tick();
    check("R8 frozen edge", dout, 10'h111);
    din = 10'h144; len_ld = 1'b0; tick();
    check("R8 resume", dout, 10'h122);
    din = 10'h155; tick();
    check("R8/R3 load on frozen edge lost", dout, 10'h144);

    // saturation: 2047 -> 1279, N = 1281
    len_val = 11'd2047; len_ld = 1'b1; din = '0;
    tick();
    len_ld = 1'b0; din = 10'h2AA;
    tick();
    din = '0;
    for (int j = 1; j <= 1280; j++) begin
      tick();
      if (j == 1279) check("R4 not yet out", dout, 10'h000);
      if (j == 1280) check("R4 saturated latency", dout, 10'h2AA);
    end

    // reset mid-run restores length 0 and delay mode
    loop_en = 1'b1;
    tick();
    rst_n = 1'b0; loop_en = 1'b0;
    #3;
    check("R1 reset clears output", dout, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;
    din = 10'h2C5;
    tick();
    din = 10'h000;
    tick();
    check("R1 length 0 and delay mode", dout, 10'h2C5);
    summary();
  end
endmodule